// File: doc/BRIEF.md
# Iterative ARX Block Cipher Core (256-bit block)

This core encrypts one 256-bit block, held as four 64-bit words, with a tweakable add-rotate-XOR cipher. After a start request the plaintext is captured into a state register and 72 rounds are applied, one per clock cycle. Each round pairs the words (0,1) and (2,3). For each pair it adds the words, rotates the second word by a round-dependent amount and XORs it into the sum. The words are then permuted. On every fourth round a subkey is added to the state before mixing. After the last round a final subkey addition produces the ciphertext.

The core does not expand the key itself. It drives a subkey index, and the surrounding logic returns that 256-bit subkey in the same cycle. The ciphertext appears together with a one-cycle completion pulse. It stays on the output until a later encryption overwrites it. The rotation amounts come from an internal table indexed by the round number modulo 8.

Top module: `arx256_core`

## Requirements
- R1: While reset is held and just after its release, `done` and `busy` are 0 and `ct` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `pt` and sets `busy` at that edge. `done` rises exactly 73 clock edges after the start edge.
- R3: After the start edge, `sk_idx` equals floor(r/4) while round r (0..71) is being computed, and equals 18 in the final-addition cycle. Between consecutive busy cycles it therefore holds or steps up by one.
- R4: Each mix on a word pair (a, b) yields x = a + b mod 2^64 and y = x XOR rotl(b, n). The pair (0,1) uses the first table constant and the pair (2,3) uses the second.
- R5: After mixing, new word i takes mixed word p(i) with p = (0,3,2,1). Word i sits at bits [64*i+63 : 64*i] of `pt`, `sk_data` and `ct`.
- R6: The rotation pairs for round r mod 8 = 0..7 are {14,16}, {52,57}, {23,40}, {5,37}, {25,33}, {46,12}, {58,22}, {32,32}.
- R7: In rounds where r mod 4 = 0, `sk_data` is added word-wise (mod 2^64) to the state before mixing. After round 71, subkey 18 is added word-wise to give `ct`.
- R8: `done` is high for exactly one cycle. `ct` does not change while `busy` is 0.
- R9: A `start` pulse while `busy` is 1 is ignored, and the running encryption completes with its original result.
- R10: `busy` stays 1 from the start edge through the final-addition cycle and is 0 in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin encryption of `pt` when idle |
| pt | input | 256 | Plaintext block, word i at bits 64*i+63:64*i |
| sk_idx | output | 5 | Index of the subkey required this cycle |
| sk_data | input | 256 | Subkey selected by `sk_idx`, valid in the same cycle |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse when `ct` is updated |
| ct | output | 256 | Ciphertext of the last completed encryption |

## Verification
A fault in the state register, the mix arithmetic, the rotation table or the permutation spreads through all four words within a few rounds. It therefore shows up as a wrong `ct` in the cycle in which `done` rises, 73 edges after the start edge. A wrong round counter shows up earlier and more directly: `sk_idx` steps at the wrong cycle, or `done` rises at the wrong latency. For that reason `sk_idx` and `busy` are sampled at every cycle of one run. Ciphertexts are compared with an independent model for several plaintext, key and tweak patterns. These include all-zero, all-one and single-bit inputs.

// File: rtl/arx256_core.sv
module arx256_core #(
  parameter int ROUNDS = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [255:0] pt,
  output logic [4:0]   sk_idx,
  input  logic [255:0] sk_data,
  output logic         busy,
  output logic         done,
  output logic [255:0] ct
);
  localparam int W  = 64;
  localparam int NW = 4;
  localparam int RW = $clog2(ROUNDS + 1);

  logic [RW-1:0]   rnd;
  logic [255:0]    st;
  logic [W-1:0]    e   [NW];
  logic [W-1:0]    f   [NW];
  logic [W-1:0]    fin [NW];
  logic [255:0]    nxt;
  logic [255:0]    fin_blk;
  logic [5:0]      ra, rb;
  logic            inject;
  logic            last;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [5:0] n);
    rotl = (x << n) | (x >> (7'd64 - {1'b0, n}));
  endfunction

  function automatic logic [11:0] rot_pair(input logic [2:0] d);
    case (d)
      3'd0: rot_pair = {6'd14, 6'd16};
      3'd1: rot_pair = {6'd52, 6'd57};
      3'd2: rot_pair = {6'd23, 6'd40};
      3'd3: rot_pair = {6'd5,  6'd37};
      3'd4: rot_pair = {6'd25, 6'd33};
      3'd5: rot_pair = {6'd46, 6'd12};
      3'd6: rot_pair = {6'd58, 6'd22};
      default: rot_pair = {6'd32, 6'd32};
    endcase
  endfunction

  assign sk_idx = 5'(rnd >> 2);
  assign inject = (rnd[1:0] == 2'b00);
  assign last   = (rnd == RW'(ROUNDS));
  assign {ra, rb} = rot_pair(rnd[2:0]);

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign e[i]   = st[W*i +: W] + (inject ? sk_data[W*i +: W] : '0);
    assign fin[i] = st[W*i +: W] + sk_data[W*i +: W];
    assign fin_blk[W*i +: W] = fin[i];
  end

  assign f[0] = e[0] + e[1];
  assign f[1] = f[0] ^ rotl(e[1], ra);
  assign f[2] = e[2] + e[3];
  assign f[3] = f[2] ^ rotl(e[3], rb);

  assign nxt = {f[1], f[2], f[3], f[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      rnd  <= '0;
      st   <= '0;
      ct   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          rnd  <= '0;
          st   <= pt;
        end
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
        ct   <= fin_blk;
      end else begin
        st  <= nxt;
        rnd <= rnd + 1'b1;
      end
    end
  end
endmodule

// File: rtl/arx256_core_chk.sv
module arx256_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [4:0]   sk_idx,
  input logic         busy,
  input logic         done,
  input logic [255:0] ct
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_ct_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ct));

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!busy || sk_idx == $past(sk_idx) || sk_idx == $past(sk_idx) + 5'd1));
endmodule

bind arx256_core arx256_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sk_idx(sk_idx),
  .busy(busy), .done(done), .ct(ct)
);

// File: tb/test_arx256_core.sv
module test_arx256_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] pt = '0;
  logic [4:0]   sk_idx;
  logic [255:0] sk_data;
  logic         busy, done;
  logic [255:0] ct;

  logic [255:0] key = '0;
  logic [127:0] twk = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  arx256_core i_arx256_core (
    .clk(clk), .rst_n(rst_n), .start(start), .pt(pt), .sk_idx(sk_idx),
    .sk_data(sk_data), .busy(busy), .done(done), .ct(ct)
  );

  function automatic logic [63:0] rl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic logic [255:0] subkey(input logic [255:0] k, input logic [127:0] t, input int s);
    logic [63:0] kw [5];
    logic [63:0] tw [3];
    logic [255:0] r;
    kw[4] = 64'h1BD11BDAA9FC1A22;
    for (int i = 0; i < 4; i++) begin
      kw[i] = k[64*i +: 64];
      kw[4] ^= kw[i];
    end
    tw[0] = t[63:0];
    tw[1] = t[127:64];
    tw[2] = tw[0] ^ tw[1];
    r[63:0]    = kw[s % 5];
    r[127:64]  = kw[(s + 1) % 5] + tw[s % 3];
    r[191:128] = kw[(s + 2) % 5] + tw[(s + 1) % 3];
    r[255:192] = kw[(s + 3) % 5] + 64'(s);
    return r;
  endfunction

  function automatic logic [255:0] model(input logic [255:0] p, input logic [255:0] k, input logic [127:0] t);
    int rot [8][2] = '{'{14,16}, '{52,57}, '{23,40}, '{5,37},
                      '{25,33}, '{46,12}, '{58,22}, '{32,32}};
    logic [63:0] v [4];
    logic [63:0] x [4];
    logic [255:0] sk;
    for (int i = 0; i < 4; i++) v[i] = p[64*i +: 64];
    for (int d = 0; d < 72; d++) begin
      if (d % 4 == 0) begin
        sk = subkey(k, t, d / 4);
        for (int i = 0; i < 4; i++) v[i] += sk[64*i +: 64];
      end
      x[0] = v[0] + v[1];
      x[1] = x[0] ^ rl(v[1], rot[d % 8][0]);
      x[2] = v[2] + v[3];
      x[3] = x[2] ^ rl(v[3], rot[d % 8][1]);
      v[0] = x[0]; v[1] = x[3]; v[2] = x[2]; v[3] = x[1];
    end
    sk = subkey(k, t, 18);
    for (int i = 0; i < 4; i++) v[i] += sk[64*i +: 64];
    return {v[3], v[2], v[1], v[0]};
  endfunction

  always_comb sk_data = subkey(key, twk, int'(sk_idx));

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [255:0] p);
    @(negedge clk);
    pt = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && busy == 1'b0, "R1 flags in reset", {254'd0, busy, done}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 flags after reset", {254'd0, busy, done}, '0);
    chk(ct == '0, "R1 ct after reset", ct, '0);
  endtask

  task automatic t_run(input logic [255:0] p, input logic [255:0] k, input logic [127:0] t, input string tag);
    int n = 0;
    logic [255:0] exp;
    logic [255:0] held;
    key = k;
    twk = t;
    exp = model(p, k, t);
    pulse_start(p);
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == 73, {"R2 latency ", tag}, 256'(n), 256'd73);
    chk(ct == exp, {"R4 R5 R6 R7 ciphertext ", tag}, ct, exp);
    held = ct;
    pt = ~p;
    @(negedge clk);
    chk(done == 1'b0, {"R8 done single cycle ", tag}, 256'(done), '0);
    repeat (3) @(negedge clk);
    chk(ct == held, {"R8 ct held ", tag}, ct, held);
  endtask

  task automatic t_schedule;
    logic [255:0] p = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F0F0F0F0F0F0F0F, 64'h5555AAAA3333CCCC};
    bit idx_ok = 1;
    bit busy_ok = 1;
    int bad_j = -1;
    key = {64'h1, 64'h2, 64'h3, 64'h4};
    twk = {64'hAAAA, 64'h5555};
    pulse_start(p);
    for (int j = 0; j <= 72; j++) begin
      if (int'(sk_idx) != j / 4 && idx_ok) begin idx_ok = 0; bad_j = j; end
      if (!busy || done) busy_ok = 0;
      if (j < 72) @(negedge clk);
    end
    chk(idx_ok, "R3 subkey index per round", 256'(bad_j), 256'(-1));
    chk(busy_ok, "R10 busy through run", 256'(busy_ok), 256'd1);
    @(negedge clk);
    chk(done && !busy, "R10 busy low with done", {254'd0, busy, done}, 256'd1);
    chk(ct == model(p, key, twk), "R7 ciphertext schedule run", ct, model(p, key, twk));
  endtask

  task automatic t_ignore_start;
    logic [255:0] p = {64'hDEADBEEF, 64'hCAFEF00D, 64'h12345678, 64'h9ABCDEF0};
    logic [255:0] exp;
    int n = 0;
    key = {4{64'h0F1E2D3C4B5A6978}};
    twk = {64'h1111, 64'h2222};
    exp = model(p, key, twk);
    pulse_start(p);
    repeat (10) @(negedge clk);
    pt = ~p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 11;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == 73, "R9 latency unchanged by start while busy", 256'(n), 256'd73);
    chk(ct == exp, "R9 result unchanged by start while busy", ct, exp);
    @(negedge clk);
    chk(!busy, "R9 no restart after done", 256'(busy), '0);
  endtask

  initial begin
    t_reset();
    t_run('0, '0, '0, "all zero");
    t_run('1, '1, '1, "all one");
    t_run({64'd3, 64'd2, 64'd1, 64'd0}, {64'h17, 64'h16, 64'h15, 64'h14},
          {64'h0706050403020100, 64'h0F0E0D0C0B0A0908}, "counting");
    t_run(256'd1 << 200, '0, 128'd1 << 127, "single bit");
    t_schedule();
    t_ignore_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule